// File: doc/BRIEF.md
# Snoop Unit Configuration Register File

This block is the configuration register window of a multi-core snoop-control unit. It decodes a 256-byte space on a simple 32-bit register bus that carries byte, halfword and word accesses. Three registers hold state or report it: an enable-style control bit, a read-only word that describes how many cores are present, and a 32-bit per-core power status word. The power status word can be reached one byte lane at a time through four consecutive offsets.

Software reads the configuration word once to discover the core count and the presence mask. It then programs the power state of each core by writing single bytes or halfwords. Several maintenance and filtering offsets exist only as placeholders. They read as zero and drop every write, so software written for fuller versions of the unit still runs unchanged. The core count is a build-time parameter from 1 to 4.

Top module: `snoop_cfg_regs`

## Requirements
- R1: A write of any valid size to offset 0x00 stores only data bit 0 in the control register. A read of offset 0x00 returns that bit in bit 0 and zero in bits 31:1.
- R2: Reset clears the control register and the power status word to zero, and leaves no read response pending.
- R3: A read of offset 0x04 returns (((1 << N) - 1) << 4) | (N - 1), where N is the parameter NUM_CORES. Writes to 0x04 change nothing.
- R4: A read of offset 0x08 returns the full power status word. Reads of 0x09, 0x0A and 0x0B return that word logically shifted right by 8, 16 and 24 bits.
- R5: A write at offset 0x08+k (k from 0 to 3) with size 1, 2 or 4 bytes replaces the bits of mask 0xFF, 0xFFFF or 0xFFFFFFFF shifted left by 8*k with the matching bits of the write data shifted left by 8*k. All other bits of the word keep their value.
- R6: Mask and data bits that the 8*k shift pushes past bit 31 are dropped. For example, a word write at 0x0B changes only bits 31:24.
- R7: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every other offset not named in R1, R3 or R4 read as zero, and writes to them change no register.
- R8: The access size input reqSize holds the byte count. A write whose reqSize is not 1, 2 or 4 is discarded and changes no register.
- R9: A read accepted on a clock edge gives rspValid high with its data after the next edge, for exactly one cycle. Writes give no response. A write changes its register on the edge where it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 8 | Byte offset in the 256-byte window |
| reqSize | input | 3 | Access size in bytes (valid: 1, 2, 4) |
| reqWdata | input | 32 | Write data, right-aligned |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 32 | Read data |

## Verification
On every cycle, the bound checker checks the one-cycle read timing and the missing response to writes. It checks that control reads return zero above bit 0, that the configuration word matches the core count, and that the placeholder offsets read as zero. It also checks that discarded writes and writes to ignored offsets leave both registers untouched, and that a full-word write at 0x08 lands exactly. The partial-lane merges, the truncation past bit 31 and the shifted views at 0x09 to 0x0B depend on earlier writes building up a known word. Only the bench's directed scenarios show those behaviours, because they track the expected word across a sequence of accesses.

// File: rtl/snoop_cfg_pkg.sv
package snoop_cfg_pkg;
  localparam int DATA_W = 32;
  localparam int OFFS_W = 8;
  localparam int SIZE_W = 3;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  localparam logic [OFFS_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [OFFS_W-1:0] OFF_CFG  = 8'h04;
  localparam logic [OFFS_W-1:0] OFF_PWR  = 8'h08;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_CTRL = 2'd1,
    RD_CFG  = 2'd2,
    RD_PWR  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic              ctrlWe;
    logic              pwrWe;
    logic [LANES-1:0]  byteEn;
    logic [LANE_W-1:0] lane;
    logic              rdEn;
    rdSel_e            rdSel;
  } strobes_t;
endpackage

// File: rtl/snoop_cfg_ctl.sv
module snoop_cfg_ctl
  import snoop_cfg_pkg::*;
(
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [OFFS_W-1:0] reqOffset,
  input  logic [SIZE_W-1:0] reqSize,
  output strobes_t          stb
);
  logic             sizeOk;
  logic [LANES-1:0] sizeEn;
  logic             isPwr;
  logic             wrOk;

  always_comb begin
    sizeOk = 1'b1;
    unique case (reqSize)
      3'd1:    sizeEn = 4'b0001;
      3'd2:    sizeEn = 4'b0011;
      3'd4:    sizeEn = 4'b1111;
      default: begin
        sizeEn = '0;
        sizeOk = 1'b0;
      end
    endcase
  end

  assign isPwr = (reqOffset[OFFS_W-1:LANE_W] == OFF_PWR[OFFS_W-1:LANE_W]);
  assign wrOk  = reqValid && reqWrite && sizeOk;

  always_comb begin
    stb.ctrlWe = wrOk && (reqOffset == OFF_CTRL);
    stb.pwrWe  = wrOk && isPwr;
    stb.lane   = reqOffset[LANE_W-1:0];
    // lanes shifted beyond the top of the word fall off the 4-bit vector
    stb.byteEn = sizeEn << reqOffset[LANE_W-1:0];
    stb.rdEn   = reqValid && !reqWrite;
    if (reqOffset == OFF_CTRL)     stb.rdSel = RD_CTRL;
    else if (reqOffset == OFF_CFG) stb.rdSel = RD_CFG;
    else if (isPwr)                stb.rdSel = RD_PWR;
    else                           stb.rdSel = RD_ZERO;
  end
endmodule

// File: rtl/snoop_cfg_dp.sv
module snoop_cfg_dp
  import snoop_cfg_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              ctrlVal,
  output logic [DATA_W-1:0] powerVal
);
  localparam int MAX_CORES = 4;
  localparam logic [1:0] CORE_ID_MAX = 2'(NUM_CORES - 1);

  logic              ctrlQ;
  logic [7:0]        powerB [LANES];
  logic [DATA_W-1:0] powerQ;
  logic [DATA_W-1:0] alignedData;
  logic [DATA_W-1:0] cfgWord;
  logic [DATA_W-1:0] rdData;

  assign alignedData = reqWdata << {stb.lane, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctrlQ <= 1'b0;
    else if (stb.ctrlWe) ctrlQ <= reqWdata[0];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           powerB[b] <= '0;
      else if (stb.pwrWe && stb.byteEn[b]) powerB[b] <= alignedData[8*b +: 8];
    end
    assign powerQ[8*b +: 8] = powerB[b];
  end

  for (genvar c = 0; c < MAX_CORES; c++) begin : g_present
    assign cfgWord[4+c] = (c < NUM_CORES);
  end
  assign cfgWord[1:0]        = CORE_ID_MAX;
  assign cfgWord[3:2]        = 2'b00;
  assign cfgWord[DATA_W-1:8] = '0;

  always_comb begin
    unique case (stb.rdSel)
      RD_CTRL: rdData = {{(DATA_W-1){1'b0}}, ctrlQ};
      RD_CFG:  rdData = cfgWord;
      RD_PWR:  rdData = powerQ >> {stb.lane, 3'b000};
      default: rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= stb.rdEn;
      if (stb.rdEn) rspRdata <= rdData;
    end
  end

  assign ctrlVal  = ctrlQ;
  assign powerVal = powerQ;
endmodule

// File: rtl/snoop_cfg_regs.sv
module snoop_cfg_regs
  import snoop_cfg_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [7:0]  reqOffset,
  input  logic [2:0]  reqSize,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspRdata
);
  strobes_t    stb;
  logic        ctrlVal;
  logic [31:0] powerVal;

  snoop_cfg_ctl u_ctl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqOffset(reqOffset),
    .reqSize  (reqSize),
    .stb      (stb)
  );

  snoop_cfg_dp #(.NUM_CORES(NUM_CORES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqWdata(reqWdata),
    .rspValid(rspValid),
    .rspRdata(rspRdata),
    .ctrlVal (ctrlVal),
    .powerVal(powerVal)
  );
endmodule

// File: rtl/snoop_cfg_chk.sv
module snoop_cfg_chk #(
  parameter int NUM_CORES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [7:0]  reqOffset,
  input logic [2:0]  reqSize,
  input logic [31:0] reqWdata,
  input logic        rspValid,
  input logic [31:0] rspRdata,
  input logic        ctrlVal,
  input logic [31:0] powerVal
);
  localparam logic [31:0] CFG_EXP =
    ((((32'd1 << NUM_CORES) - 32'd1) << 4) | 32'(NUM_CORES - 1));

  logic sizeOk;
  logic zeroOff;
  assign sizeOk  = (reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4);
  assign zeroOff = !(reqOffset == 8'h00 || reqOffset == 8'h04 ||
                     reqOffset[7:2] == 6'h02);

  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);
  a_r9_no_extra_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);
  a_r1_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqOffset) == 8'h00) |-> (rspRdata[31:1] == 31'd0));
  a_r3_cfg_value: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqOffset) == 8'h04) |-> (rspRdata == CFG_EXP));
  a_r7_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(zeroOff)) |-> (rspRdata == 32'd0));
  a_r7_ignored_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && (zeroOff || reqOffset == 8'h04)) |=>
      ($stable(powerVal) && $stable(ctrlVal)));
  a_r8_bad_size: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !sizeOk) |=> ($stable(powerVal) && $stable(ctrlVal)));
  a_r5_full_word: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 3'd4 && reqOffset == 8'h08) |=>
      (powerVal == $past(reqWdata)));
endmodule

bind snoop_cfg_regs snoop_cfg_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqOffset(reqOffset),
  .reqSize  (reqSize),
  .reqWdata (reqWdata),
  .rspValid (rspValid),
  .rspRdata (rspRdata),
  .ctrlVal  (ctrlVal),
  .powerVal (powerVal)
);

// File: tb/snoop_cfg_regs_bench.sv
`timescale 1ns/1ps
module snoop_cfg_regs_bench;
  localparam int NCORES = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqOffset = '0;
  logic [2:0]  reqSize = 3'd4;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] expPwr;
  logic        expCtrl;

  always #2.5 clk = ~clk;

  snoop_cfg_regs #(.NUM_CORES(NCORES)) u_snoop_cfg_regs (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqOffset = off; reqSize = sz; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    check("R9 no response to write", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic doRead(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqOffset = off; reqSize = 3'd4;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 read response valid", {31'd0, rspValid}, 32'd1);
    d = rspRdata;
    @(negedge clk);
    check("R9 response one cycle", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R2 no pending response", {31'd0, rspValid}, 32'd0);
    doRead(8'h00, d); check("R2 control reset", d, 32'd0);
    doRead(8'h08, d); check("R2 power reset", d, 32'd0);
  endtask

  task automatic testCtrl();
    logic [31:0] d;
    doWrite(8'h00, 3'd4, 32'hFFFF_FFFF); expCtrl = 1'b1;
    doRead(8'h00, d); check("R1 keep bit0 only", d, {31'd0, expCtrl});
    doWrite(8'h00, 3'd1, 32'h0000_00FE); expCtrl = 1'b0;
    doRead(8'h00, d); check("R1 bit0 cleared", d, 32'd0);
    doWrite(8'h00, 3'd2, 32'h0000_0001); expCtrl = 1'b1;
    doRead(8'h00, d); check("R1 halfword write", d, 32'd1);
  endtask

  task automatic testCfg();
    logic [31:0] d;
    logic [31:0] exp;
    exp = (((32'd1 << NCORES) - 1) << 4) | (NCORES - 1);
    doRead(8'h04, d); check("R3 config word", d, exp);
    doWrite(8'h04, 3'd4, 32'h0000_0000);
    doRead(8'h04, d); check("R3 config write ignored", d, exp);
  endtask

  task automatic testPower();
    logic [31:0] d;
    doWrite(8'h08, 3'd4, 32'h1122_3344); expPwr = 32'h1122_3344;
    doRead(8'h08, d); check("R4 full word", d, expPwr);
    doRead(8'h09, d); check("R4 shift 8", d, expPwr >> 8);
    doRead(8'h0A, d); check("R4 shift 16", d, expPwr >> 16);
    doRead(8'h0B, d); check("R4 shift 24", d, expPwr >> 24);
    doWrite(8'h0A, 3'd1, 32'hAAAA_BBCC); expPwr = 32'h11CC_3344;
    doRead(8'h08, d); check("R5 byte at lane 2", d, expPwr);
    doWrite(8'h09, 3'd2, 32'h5555_DEAD); expPwr = 32'h11DE_AD44;
    doRead(8'h08, d); check("R5 halfword at lane 1", d, expPwr);
    doWrite(8'h08, 3'd1, 32'h0000_0077); expPwr = 32'h11DE_AD77;
    doRead(8'h08, d); check("R5 byte at lane 0", d, expPwr);
  endtask

  task automatic testTruncate();
    logic [31:0] d;
    doWrite(8'h0B, 3'd4, 32'h1234_5678); expPwr = {8'h78, expPwr[23:0]};
    doRead(8'h08, d); check("R6 word at lane 3", d, expPwr);
    doWrite(8'h0B, 3'd2, 32'h0000_ABCD); expPwr = {8'hCD, expPwr[23:0]};
    doRead(8'h08, d); check("R6 halfword at lane 3", d, expPwr);
    doWrite(8'h0A, 3'd4, 32'hCAFE_F00D); expPwr = {16'hF00D, expPwr[15:0]};
    doRead(8'h08, d); check("R6 word at lane 2", d, expPwr);
  endtask

  task automatic testZeroRegs();
    logic [31:0] d;
    logic [7:0] offs [8] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01, 8'h80, 8'hFF};
    for (int i = 0; i < 8; i++) begin
      doWrite(offs[i], 3'd4, 32'hFFFF_FFFE);
      doRead(offs[i], d); check("R7 reads zero", d, 32'd0);
    end
    doRead(8'h00, d); check("R7 control untouched", d, {31'd0, expCtrl});
    doRead(8'h08, d); check("R7 power untouched", d, expPwr);
  endtask

  task automatic testBadSize();
    logic [31:0] d;
    doWrite(8'h00, 3'd3, 32'h0000_0000);
    doWrite(8'h08, 3'd0, 32'h0000_0000);
    doWrite(8'h09, 3'd7, 32'h0000_0000);
    doRead(8'h00, d); check("R8 control kept", d, {31'd0, expCtrl});
    doRead(8'h08, d); check("R8 power kept", d, expPwr);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    expPwr = '0; expCtrl = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCtrl();
    testCfg();
    testPower();
    testTruncate();
    testZeroRegs();
    testBadSize();
    done = 1'b1;
    summary();
  end
endmodule